// File: doc/BRIEF.md
# Prioritized Address Select Decoder

This block turns a 16-bit CPU address into exactly one resource select. Seven resources are possible: the debug firmware space, the internal register space, the RAM, the EEPROM, the fixed ROM, the program page window and the external space. The positions of the relocatable resources come from mapping fields held in a register bank elsewhere. The sizes come from integration straps. The operating mode decides whether an address that no internal resource claims selects external space or selects nothing.

Every resource is first decoded on its own into a request. A fixed priority chain then keeps the highest-priority request. The result is registered, so `sel_o` shows the decision for the address and controls that were present at the previous rising clock edge. The RAM decoder handles eight size codes, each with its own relocation granularity. It also places the RAM at the bottom or the top of its mappable region, following an alignment flag.

Top module: `addr_sel_decoder`

## Requirements
- R1: `sel_o` is zero while `rst_n` is low. After reset, `sel_o` gives the decision for the `addr_i` and control inputs sampled at the previous rising edge of `clk`.
- R2: At most one bit of `sel_o` is set. The bit positions are: 0 debug, 1 registers, 2 RAM, 3 EEPROM, 4 fixed ROM, 5 page window, 6 external. When several resources claim an address, the lowest-numbered bit wins.
- R3: The debug space covers addresses 0xFF00 to 0xFFFF. It is requested only while `dbg_active_i` is 1.
- R4: The register space starts at `reg_pos_i` × 0x800, which is always below 0x8000. It is 2K bytes long when `reg_2k_i` is 1. When `reg_2k_i` is 0 it is 1K bytes long: only the lower half of that 2K block.
- R5: Where the register space and the RAM overlap, the register select wins. The RAM cannot be reached at those addresses.
- R6: `ram_size_i` codes 0 to 7 give a RAM of (code+1) × 2K bytes. The mappable regions are 2K, 4K, 8K, 8K, 16K, 16K, 16K and 16K bytes. The region base is `ram_pos_i` × 0x800 rounded down to a multiple of the region size.
- R7: When the RAM is smaller than its region, `ram_hi_align_i` = 0 puts it at the region bottom. `ram_hi_align_i` = 1 puts it so that it ends at the region top.
- R8: The EEPROM is requested only when `ee_en_i` is 1. `ee_size_i` = 1 gives 2K bytes and `ee_size_i` = 2 gives 4K bytes. Codes 0 and 3 give no EEPROM. The base is `ee_pos_i` × 0x800 rounded down to a multiple of the size.
- R9: The fixed ROM at 0xC000 to 0xFFFF is requested only when `rom_en_i` is 1.
- R10: When `rom_en_i` is 1 and `rom_high_only_i` is 0, the fixed ROM also claims 0x0000 to 0x7FFF. When `rom_high_only_i` is 1, those lower addresses are not given to the ROM, while 0x8000 to 0xBFFF still selects the page window.
- R11: Addresses 0x8000 to 0xBFFF select the page window whenever no higher-priority resource claims them.
- R12: An address that no internal resource claims selects external space when `expanded_i` is 1. It selects nothing when `expanded_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| dbg_active_i | input | 1 | Debug firmware space is mapped in |
| expanded_i | input | 1 | Expanded mode: unclaimed addresses are external |
| reg_pos_i | input | 4 | Register space position, address bits 14:11 |
| reg_2k_i | input | 1 | Strap: register space is 2K (1) or 1K (0) |
| ram_pos_i | input | 5 | RAM position, address bits 15:11 |
| ram_hi_align_i | input | 1 | RAM aligned to the top of its region |
| ram_size_i | input | 3 | Strap: RAM size code |
| ee_pos_i | input | 5 | EEPROM position, address bits 15:11 |
| ee_en_i | input | 1 | EEPROM enable |
| ee_size_i | input | 2 | Strap: EEPROM size code |
| rom_en_i | input | 1 | Fixed ROM enable |
| rom_high_only_i | input | 1 | Keep fixed ROM out of the lower half |
| sel_o | output | 7 | Registered one-hot select |

## Verification
The assertions compare each registered select with the inputs one edge earlier through `$past`. They therefore assume that the address and every control input are held stable across the sampling edge, and that the bench applies a new value only away from that edge. The bench changes the inputs only on the falling clock edge and keeps each configuration fixed for its whole address sweep. The sweep covers both ends of every 128-byte slice. This reaches every region boundary, because each boundary is a multiple of 0x100.

// File: rtl/addr_sel_pkg.sv
package addr_sel_pkg;
   localparam int SEL_N   = 7;
   localparam int SEL_DBG = 0;
   localparam int SEL_REG = 1;
   localparam int SEL_RAM = 2;
   localparam int SEL_EE  = 3;
   localparam int SEL_ROM = 4;
   localparam int SEL_WIN = 5;
   localparam int SEL_EXT = 6;

   typedef logic [SEL_N-1:0] sel_vec_t;
endpackage

// File: rtl/addr_sel_block.sv
module addr_sel_block #(
   parameter int ADDR_W = 16,
   parameter int LG     = 11
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   output logic              hit
);
   localparam int TOP_W = ADDR_W - LG;

   if (LG < 1 || LG >= ADDR_W) begin : g_bad_lg
      initial $fatal(1, "addr_sel_block: LG out of range");
   end

   assign hit = (addr[ADDR_W-1:LG] == base[ADDR_W-1:LG]) && (TOP_W > 0);
endmodule

// File: rtl/addr_sel_ram.sv
module addr_sel_ram #(
   parameter int ADDR_W = 16,
   parameter int GRAN_LG = 11,
   parameter int CODE_W = 3
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [ADDR_W-GRAN_LG-1:0] pos,
   input  logic [CODE_W-1:0]         size_code,
   input  logic                      hi_align,
   output logic                      hit
);
   localparam int SH_W = $clog2(ADDR_W + 1);

   logic [SH_W-1:0]   region_lg;
   logic [ADDR_W-1:0] region_bytes;
   logic [ADDR_W-1:0] region_mask;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] alloc_bytes;
   logic              in_region;
   logic              in_alloc;

   always_comb begin
      case (size_code)
         3'd0:       region_lg = SH_W'(GRAN_LG);
         3'd1:       region_lg = SH_W'(GRAN_LG + 1);
         3'd2, 3'd3: region_lg = SH_W'(GRAN_LG + 2);
         default:    region_lg = SH_W'(GRAN_LG + 3);
      endcase
   end

   assign region_bytes = ADDR_W'(1) << region_lg;
   assign region_mask  = ~(region_bytes - ADDR_W'(1));
   assign base         = {pos, {GRAN_LG{1'b0}}};
   assign offset       = addr & ~region_mask;
   assign alloc_bytes  = (ADDR_W'(size_code) + ADDR_W'(1)) << GRAN_LG;
   assign in_region    = ((addr ^ base) & region_mask) == '0;
   assign in_alloc     = hi_align ? (offset >= (region_bytes - alloc_bytes))
                                  : (offset < alloc_bytes);
   assign hit          = in_region && in_alloc;
endmodule

// File: rtl/addr_sel_prio.sv
module addr_sel_prio #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [N:0] taken;

   assign taken[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]   = req[i] & ~taken[i];
      assign taken[i+1] = taken[i] | req[i];
   end
endmodule

// File: rtl/addr_sel_decoder.sv
module addr_sel_decoder
   import addr_sel_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          GRAN_LG  = 11,
   parameter int          WIN_LG   = 14,
   parameter int          DBG_LG   = 8,
   parameter logic [15:0] DBG_BASE = 16'hFF00,
   parameter int          EE_SIZES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] addr_i,
   input  logic        dbg_active_i,
   input  logic        expanded_i,
   input  logic [3:0]  reg_pos_i,
   input  logic        reg_2k_i,
   input  logic [4:0]  ram_pos_i,
   input  logic        ram_hi_align_i,
   input  logic [2:0]  ram_size_i,
   input  logic [4:0]  ee_pos_i,
   input  logic        ee_en_i,
   input  logic [1:0]  ee_size_i,
   input  logic        rom_en_i,
   input  logic        rom_high_only_i,
   output logic [6:0]  sel_o
);
   localparam int POS_W   = ADDR_W - GRAN_LG;
   localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(2) << WIN_LG;

   if (ADDR_W != 16 || GRAN_LG != 11) begin : g_bad_map
      initial $fatal(1, "addr_sel_decoder: map geometry must be 16/11");
   end
   if (DBG_LG > WIN_LG || (DBG_BASE & ((16'd1 << DBG_LG) - 16'd1)) != 16'd0) begin : g_bad_dbg
      initial $fatal(1, "addr_sel_decoder: debug space misaligned");
   end
   if (EE_SIZES < 1 || EE_SIZES > 2) begin : g_bad_ee
      initial $fatal(1, "addr_sel_decoder: EE_SIZES must be 1 or 2");
   end

   sel_vec_t req;
   sel_vec_t grant;
   sel_vec_t sel_q;

   logic dbg_hit, reg_hit, ram_hit, win_hit;
   logic [EE_SIZES-1:0] ee_hit;

   addr_sel_block #(.ADDR_W(ADDR_W), .LG(DBG_LG)) u_dbg (
      .addr(addr_i), .base(DBG_BASE), .hit(dbg_hit));

   addr_sel_block #(.ADDR_W(ADDR_W), .LG(GRAN_LG)) u_reg (
      .addr(addr_i), .base({1'b0, reg_pos_i, {GRAN_LG{1'b0}}}), .hit(reg_hit));

   addr_sel_block #(.ADDR_W(ADDR_W), .LG(WIN_LG)) u_win (
      .addr(addr_i), .base(WIN_BASE), .hit(win_hit));

   for (genvar g = 0; g < EE_SIZES; g++) begin : g_ee
      addr_sel_block #(.ADDR_W(ADDR_W), .LG(GRAN_LG + g)) u_ee (
         .addr(addr_i), .base({ee_pos_i, {GRAN_LG{1'b0}}}), .hit(ee_hit[g]));
   end

   addr_sel_ram #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .CODE_W(3)) u_ram (
      .addr(addr_i), .pos(ram_pos_i[POS_W-1:0]), .size_code(ram_size_i),
      .hi_align(ram_hi_align_i), .hit(ram_hit));

   logic ee_sized_hit;
   always_comb begin
      ee_sized_hit = 1'b0;
      for (int k = 0; k < EE_SIZES; k++) begin
         if (ee_size_i == 2'(k + 1)) ee_sized_hit = ee_hit[k];
      end
   end

   always_comb begin
      req          = '0;
      req[SEL_DBG] = dbg_active_i & dbg_hit;
      req[SEL_REG] = reg_hit & (reg_2k_i | ~addr_i[GRAN_LG-1]);
      req[SEL_RAM] = ram_hit;
      req[SEL_EE]  = ee_en_i & ee_sized_hit;
      req[SEL_ROM] = rom_en_i & ((addr_i[15:14] == 2'b11) |
                                 (~addr_i[15] & ~rom_high_only_i));
      req[SEL_WIN] = win_hit;
      req[SEL_EXT] = expanded_i;
   end

   addr_sel_prio #(.N(SEL_N)) u_prio (.req(req), .grant(grant));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= grant;
   end

   assign sel_o = sel_q;

   AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_q)); // R2
   AST_REG_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[SEL_REG] |-> !$past(addr_i[15])); // R4
   AST_EE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[SEL_EE] |-> $past(ee_en_i)); // R8
   AST_ROM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[SEL_ROM] |-> $past(rom_en_i)); // R9
   AST_ROM_LOW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[SEL_ROM] && $past(rom_high_only_i)) |-> $past(addr_i[15])); // R10
   AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[SEL_WIN] |-> ($past(addr_i[15:14]) == 2'b10)); // R11
   AST_EXT_EXPANDED: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[SEL_EXT] |-> $past(expanded_i)); // R12
endmodule

// File: tb/addr_sel_decoder_tb.sv
`timescale 1ns/1ps
module addr_sel_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        dbg_active = 1'b0;
   logic        expanded = 1'b0;
   logic [3:0]  reg_pos = '0;
   logic        reg_2k = 1'b0;
   logic [4:0]  ram_pos = '0;
   logic        ram_hi = 1'b0;
   logic [2:0]  ram_size = '0;
   logic [4:0]  ee_pos = '0;
   logic        ee_en = 1'b0;
   logic [1:0]  ee_size = '0;
   logic        rom_en = 1'b0;
   logic        rom_ho = 1'b0;
   logic [6:0]  sel_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   addr_sel_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .dbg_active_i(dbg_active),
      .expanded_i(expanded), .reg_pos_i(reg_pos), .reg_2k_i(reg_2k),
      .ram_pos_i(ram_pos), .ram_hi_align_i(ram_hi), .ram_size_i(ram_size),
      .ee_pos_i(ee_pos), .ee_en_i(ee_en), .ee_size_i(ee_size),
      .rom_en_i(rom_en), .rom_high_only_i(rom_ho), .sel_o(sel_o));

   function automatic logic [6:0] expect_sel(input int a);
      int rb, alloc, rbase, rstart, sz, base;
      bit [6:0] hit;
      hit = '0;
      hit[0] = dbg_active && a >= 'hFF00;
      sz = reg_2k ? 2048 : 1024;
      base = int'(reg_pos) * 2048;
      hit[1] = a >= base && a < base + sz;
      case (ram_size)
         0: rb = 2048; 1: rb = 4096; 2, 3: rb = 8192; default: rb = 16384;
      endcase
      alloc = (int'(ram_size) + 1) * 2048;
      rbase = (int'(ram_pos) * 2048 / rb) * rb;
      rstart = ram_hi ? rbase + rb - alloc : rbase;
      hit[2] = a >= rstart && a < rstart + alloc;
      sz = (ee_size == 1) ? 2048 : (ee_size == 2) ? 4096 : 0;
      if (sz != 0) begin
         base = (int'(ee_pos) * 2048 / sz) * sz;
         hit[3] = ee_en && a >= base && a < base + sz;
      end
      hit[4] = rom_en && (a >= 'hC000 || (a < 'h8000 && !rom_ho));
      hit[5] = a >= 'h8000 && a < 'hC000;
      hit[6] = expanded;
      for (int i = 0; i < 7; i++) if (hit[i]) return 7'(1 << i);
      return '0;
   endfunction

   function automatic string tag_of(input logic [6:0] s);
      case (s)
         7'b0000001: return "R3";
         7'b0000010: return "R4";
         7'b0000100: return "R6";
         7'b0001000: return "R8";
         7'b0010000: return "R9";
         7'b0100000: return "R11";
         default:    return "R12";
      endcase
   endfunction

   task automatic check_at(input int a, input string tag);
      logic [6:0] exp;
      @(negedge clk);
      addr = 16'(a);
      exp = expect_sel(a);
      @(negedge clk);
      checks++;
      if (sel_o !== exp) begin
         errors++;
         $display("FAIL %s addr=%h actual=%b expected=%b", (tag == "") ? tag_of(exp) : tag,
                  16'(a), sel_o, exp);
      end
   endtask

   task automatic set_cfg(input int c);
      @(negedge clk);
      ram_size   = 3'(c % 8);
      ram_hi     = 1'((c / 8) % 2);
      ram_pos    = 5'((c * 7) % 32);
      reg_pos    = 4'((c * 5) % 16);
      reg_2k     = 1'((c / 2) % 2);
      ee_en      = (c % 3) != 0;
      ee_size    = 2'(c % 4);
      ee_pos     = 5'((c * 11 + 3) % 32);
      rom_en     = 1'((c / 4) % 2);
      rom_ho     = 1'((c / 3) % 2);
      expanded   = 1'((c / 5) % 2);
      dbg_active = (c % 5) == 0;
   endtask

   task automatic clear_cfg();
      @(negedge clk);
      dbg_active = 0; expanded = 0; reg_pos = 0; reg_2k = 0; ram_pos = 0;
      ram_hi = 0; ram_size = 0; ee_pos = 0; ee_en = 0; ee_size = 0;
      rom_en = 0; rom_ho = 0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      addr = 16'h8000; rom_en = 1; expanded = 1;
      repeat (3) @(negedge clk);
      checks++;
      if (sel_o !== 7'd0) begin
         errors++;
         $display("FAIL R1 reset: actual=%b expected=%b", sel_o, 7'd0);
      end
      rst_n = 1'b1;

      // R5: register space over RAM
      clear_cfg();
      reg_pos = 4'd1; ram_pos = 5'd1; ram_size = 3'd0;
      check_at('h0900, "R5");
      check_at('h0C00, "R5");
      reg_2k = 1;
      check_at('h0C00, "R5");

      // R7: 6K RAM inside 8K region, both alignments
      clear_cfg();
      ram_size = 3'd2; ram_pos = 5'd4;
      check_at('h2000, "R7");
      check_at('h37FF, "R7");
      check_at('h3800, "R7");
      ram_hi = 1;
      check_at('h2000, "R7");
      check_at('h27FF, "R7");
      check_at('h2800, "R7");
      check_at('h3FFF, "R7");

      // R10: lower ROM kept out, window still reachable
      clear_cfg();
      ram_pos = 5'd31; rom_en = 1; rom_ho = 1;
      check_at('h4000, "R10");
      check_at('h8000, "R10");
      check_at('hC000, "R10");
      rom_ho = 0;
      check_at('h4000, "R10");

      // R2: debug wins over ROM; R12 single-chip gives nothing
      dbg_active = 1;
      check_at('hFF80, "R2");
      check_at('hFEFF, "R2");
      clear_cfg();
      ram_pos = 5'd31;
      check_at('h6000, "R12");
      expanded = 1;
      check_at('h6000, "R12");

      // R1: one-edge latency over a sweep of many configurations
      for (int c = 0; c < 24; c++) begin
         set_cfg(c);
         for (int k = 0; k < 512; k++) begin
            check_at(k * 128, "");
            check_at(k * 128 + 127, "");
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule